// File: doc/BRIEF.md
# Processor Reset Qualifier with Bus Idle Gating

This block sits between a processor core and its external pins. It samples the level-sensitive, clock-synchronous reset request, measures how many clock periods the request stays high, and decides from that width whether the core is really to be reset. A request shorter than the minimum width is rejected and leaves the core running. A request that lasts long enough also asks for the built-in self test. That request is issued as a single-cycle pulse once the reset request is released.

For as long as the reset request is sampled high, and for as long as the core is held in reset, the block overrides every bus pin with a fixed idle pattern. It also blocks the bus-hold handshake, so reset wins over hold even when hold was granted beforehand. At all other times the core's bus outputs and the hold handshake pass straight through.

Top module: `reset_bus_gate`

## Requirements
- R1: A reset request sampled high for fewer than 15 consecutive clock cycles never asserts `core_reset` or `selftest_req`.
- R2: A reset request sampled high for 15 or more cycles asserts `core_reset`. The request is registered once on entry. With the request high for L cycles, `core_reset` is high in the cycle after the request input is lowered and is low one cycle later.
- R3: While the forcing condition holds (the request is sampled high, or `core_reset` is high), the pins take their idle values: `pin_ads_n`=1, `pin_data_oe`=0 (data bus released), `pin_data_out`=0, `pin_be_n`=all zeros, `pin_addr`=all ones, `pin_wr`=0, `pin_dc`=1, `pin_mio`=0, `pin_lock_n`=1.
- R4: While the forcing condition holds, `pin_hlda` and `core_hold` are 0 whatever `hold_req` and `core_hlda` do, including when hold acknowledge was already high before reset.
- R5: A qualified request lasting 80 or more cycles gives `selftest_req` high for exactly one cycle: the cycle in which `core_reset` has just fallen.
- R6: A qualified request lasting from 15 to 79 cycles never raises `selftest_req`.
- R7: The width counter saturates instead of wrapping, so a request of 128 or more cycles still yields both `core_reset` and `selftest_req`.
- R8: Outside the forcing condition, every pin equals the matching core output, `pin_hlda` equals `core_hlda`, and `core_hold` equals `hold_req`.
- R9: With `rst_n` low, `core_reset` and `selftest_req` are 0 and the width measurement restarts, even while a reset request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of this block's own state |
| cpu_reset_in | input | 1 | Processor reset request, level, synchronous |
| hold_req | input | 1 | External bus-hold request |
| core_hlda | input | 1 | Hold acknowledge from the core |
| core_ads_n | input | 1 | Core address strobe, active low |
| core_be_n | input | 4 | Core byte enables, active low |
| core_addr | input | 30 | Core word address |
| core_wr | input | 1 | Core write (1) / read (0) |
| core_dc | input | 1 | Core data (1) / control (0) |
| core_mio | input | 1 | Core memory (1) / IO (0) |
| core_lock_n | input | 1 | Core bus lock, active low |
| core_data_out | input | 32 | Core write data |
| core_data_oe | input | 1 | Core data drive enable |
| pin_ads_n | output | 1 | Gated address strobe |
| pin_be_n | output | 4 | Gated byte enables |
| pin_addr | output | 30 | Gated address |
| pin_wr | output | 1 | Gated write/read |
| pin_dc | output | 1 | Gated data/control |
| pin_mio | output | 1 | Gated memory/IO |
| pin_lock_n | output | 1 | Gated lock |
| pin_data_out | output | 32 | Gated write data |
| pin_data_oe | output | 1 | Data pad drive enable, 0 = high impedance |
| pin_hlda | output | 1 | Hold acknowledge to the pins |
| core_hold | output | 1 | Hold request passed to the core |
| core_reset | output | 1 | Qualified reset to the core |
| selftest_req | output | 1 | One-cycle self-test request |

## Verification
The bench targets the width thresholds exactly: 14 against 15 cycles for qualification, 79 against 80 for self test, and 130 cycles, where a counter that wraps would read a short width and lose both outputs. A design that is off by one at a threshold would reset or self-test on the wrong pulse. The bench checks the cycle right after release, when a short pulse must already pass the core's bus through while a qualified one must still hold the idle pattern; a design that keys forcing on the raw request alone would release the bus a cycle early. It also grants hold before reset starts, which catches a design that lets a prior acknowledge survive into reset, and it drops `rst_n` in the middle of a long request.

// File: rtl/rbi_pkg.sv
// Package: shared types and idle levels for the reset qualifier and bus gate.
// Assumes the control pins are single bits whose idle level does not depend on
// any width parameter.
package rbi_pkg;

    typedef struct packed {
        logic ads_n;
        logic wr;
        logic dc;
        logic mio;
        logic lock_n;
    } ctl_pins_t;

    localparam ctl_pins_t CTL_IDLE = '{ads_n: 1'b1, wr: 1'b0, dc: 1'b1, mio: 1'b0, lock_n: 1'b1};

endpackage

// File: rtl/rbi_width_meter.sv
// Module: measures the width of the sampled reset request with a saturating
// counter, qualifies it against a minimum width and decides the self test on
// release. Assumes rst_lvl is already registered to clk.
module rbi_width_meter #(
    parameter int CNT_W        = 7,
    parameter int RESET_MIN    = 15,
    parameter int SELFTEST_MIN = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_lvl,
    output logic             core_reset,
    output logic             selftest_req,
    output logic [CNT_W-1:0] run_len
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] QUAL_LIM = CNT_W'(RESET_MIN);
    localparam logic [CNT_W-1:0] ST_LIM   = CNT_W'(SELFTEST_MIN);

    logic [CNT_W-1:0] next_len;
    logic             core_reset_q;
    logic             st_q;

    // Next width: count while high, hold at the ceiling, clear when low.
    always_comb begin
        if (!rst_lvl)
            next_len = '0;
        else if (run_len == CNT_MAX)
            next_len = run_len;
        else
            next_len = run_len + 1'b1;
    end

    // Width register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else
            run_len <= next_len;
    end

    // Qualified core reset: set once the width reaches the minimum, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            core_reset_q <= 1'b0;
        else if (rst_lvl)
            core_reset_q <= core_reset_q | (next_len >= QUAL_LIM);
        else
            core_reset_q <= 1'b0;
    end

    // Self-test pulse: first low cycle after a request long enough for self test.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= 1'b0;
        else
            st_q <= !rst_lvl && (run_len >= ST_LIM);
    end

    assign core_reset   = core_reset_q;
    assign selftest_req = st_q;

endmodule

// File: rtl/rbi_bus_gate.sv
// Module: replaces the core's bus outputs with the idle pattern while force is
// high and passes them through otherwise. Purely combinational; assumes the
// caller registers force.
module rbi_bus_gate
    import rbi_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              force_idle,
    input  ctl_pins_t         core_ctl,
    input  logic [BE_W-1:0]   core_be_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_data,
    input  logic              core_oe,
    output ctl_pins_t         pin_ctl,
    output logic [BE_W-1:0]   pin_be_n,
    output logic [ADDR_W-1:0] pin_addr,
    output logic [DATA_W-1:0] pin_data,
    output logic              pin_oe
);
    // Select idle levels or the core's values.
    always_comb begin
        if (force_idle) begin
            pin_ctl  = CTL_IDLE;
            pin_be_n = '0;
            pin_addr = '1;
            pin_data = '0;
            pin_oe   = 1'b0;
        end else begin
            pin_ctl  = core_ctl;
            pin_be_n = core_be_n;
            pin_addr = core_addr;
            pin_data = core_data;
            pin_oe   = core_oe;
        end
    end

endmodule

// File: rtl/rbi_hold_gate.sv
// Module: blocks the bus-hold handshake in both directions while reset forces
// the bus idle, so reset takes precedence over a pending or granted hold.
module rbi_hold_gate (
    input  logic force_idle,
    input  logic hold_req,
    input  logic core_hlda,
    output logic core_hold,
    output logic pin_hlda
);
    // Gate both directions of the handshake.
    always_comb begin
        core_hold = hold_req  && !force_idle;
        pin_hlda  = core_hlda && !force_idle;
    end

endmodule

// File: rtl/reset_bus_gate.sv
// Module: top of the reset qualifier. Registers the reset request once, measures
// and qualifies its width, and holds the bus and hold handshake idle while the
// request is sampled high or the core is in reset. Assumes cpu_reset_in is
// synchronous to clk.
module reset_bus_gate
    import rbi_pkg::*;
#(
    parameter int CNT_W        = 7,
    parameter int RESET_MIN    = 15,
    parameter int SELFTEST_MIN = 80,
    parameter int ADDR_W       = 30,
    parameter int DATA_W       = 32,
    parameter int BE_W         = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_reset_in,
    input  logic              hold_req,
    input  logic              core_hlda,
    input  logic              core_ads_n,
    input  logic [BE_W-1:0]   core_be_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_wr,
    input  logic              core_dc,
    input  logic              core_mio,
    input  logic              core_lock_n,
    input  logic [DATA_W-1:0] core_data_out,
    input  logic              core_data_oe,
    output logic              pin_ads_n,
    output logic [BE_W-1:0]   pin_be_n,
    output logic [ADDR_W-1:0] pin_addr,
    output logic              pin_wr,
    output logic              pin_dc,
    output logic              pin_mio,
    output logic              pin_lock_n,
    output logic [DATA_W-1:0] pin_data_out,
    output logic              pin_data_oe,
    output logic              pin_hlda,
    output logic              core_hold,
    output logic              core_reset,
    output logic              selftest_req
);
    logic             rst_lvl;
    logic             bus_force;
    logic [CNT_W-1:0] run_len;
    ctl_pins_t        core_ctl;
    ctl_pins_t        pin_ctl;

    // Sample the reset request level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_lvl <= 1'b0;
        else
            rst_lvl <= cpu_reset_in;
    end

    rbi_width_meter #(
        .CNT_W(CNT_W), .RESET_MIN(RESET_MIN), .SELFTEST_MIN(SELFTEST_MIN)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .rst_lvl(rst_lvl),
        .core_reset(core_reset), .selftest_req(selftest_req), .run_len(run_len)
    );

    // Forcing covers the sampled request and the whole qualified reset.
    assign bus_force = rst_lvl | core_reset;

    // Pack the core's control pins.
    always_comb begin
        core_ctl.ads_n  = core_ads_n;
        core_ctl.wr     = core_wr;
        core_ctl.dc     = core_dc;
        core_ctl.mio    = core_mio;
        core_ctl.lock_n = core_lock_n;
    end

    rbi_bus_gate #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
    ) u_bus (
        .force_idle(bus_force), .core_ctl(core_ctl), .core_be_n(core_be_n),
        .core_addr(core_addr), .core_data(core_data_out), .core_oe(core_data_oe),
        .pin_ctl(pin_ctl), .pin_be_n(pin_be_n), .pin_addr(pin_addr),
        .pin_data(pin_data_out), .pin_oe(pin_data_oe)
    );

    rbi_hold_gate u_hold (
        .force_idle(bus_force), .hold_req(hold_req), .core_hlda(core_hlda),
        .core_hold(core_hold), .pin_hlda(pin_hlda)
    );

    // Unpack the gated control pins.
    always_comb begin
        pin_ads_n  = pin_ctl.ads_n;
        pin_wr     = pin_ctl.wr;
        pin_dc     = pin_ctl.dc;
        pin_mio    = pin_ctl.mio;
        pin_lock_n = pin_ctl.lock_n;
    end

endmodule

// File: rtl/reset_bus_gate_chk.sv
// Checker: temporal properties of the reset qualifier, bound into the top.
module reset_bus_gate_chk #(
    parameter int CNT_W        = 7,
    parameter int RESET_MIN    = 15,
    parameter int SELFTEST_MIN = 80,
    parameter int ADDR_W       = 30,
    parameter int DATA_W       = 32,
    parameter int BE_W         = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_force,
    input logic              core_reset,
    input logic              selftest_req,
    input logic [CNT_W-1:0]  run_len,
    input logic              pin_ads_n,
    input logic [BE_W-1:0]   pin_be_n,
    input logic [ADDR_W-1:0] pin_addr,
    input logic              pin_wr,
    input logic              pin_dc,
    input logic              pin_mio,
    input logic              pin_lock_n,
    input logic [DATA_W-1:0] pin_data_out,
    input logic              pin_data_oe,
    input logic              pin_hlda,
    input logic              core_hold,
    input logic [ADDR_W-1:0] core_addr,
    input logic              core_hlda
);
    localparam logic [CNT_W-1:0] QUAL_LIM = CNT_W'(RESET_MIN);
    localparam logic [CNT_W-1:0] ST_LIM   = CNT_W'(SELFTEST_MIN);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_force |-> (pin_ads_n && !pin_data_oe && pin_be_n == '0 && (&pin_addr)
                       && !pin_wr && pin_dc && !pin_mio && pin_lock_n && pin_data_out == '0));

    p_hold_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_force |-> (!pin_hlda && !core_hold));

    p_qual_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_reset) |-> run_len >= QUAL_LIM);

    p_st_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_req |=> !selftest_req);

    p_st_after_long_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selftest_req) |-> ($past(core_reset) && $past(run_len) >= ST_LIM && !core_reset));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_len == CNT_MAX) |=> (run_len == CNT_MAX || run_len == '0));

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_force |-> (pin_addr == core_addr && pin_hlda == core_hlda));

endmodule

bind reset_bus_gate reset_bus_gate_chk #(
    .CNT_W(CNT_W), .RESET_MIN(RESET_MIN), .SELFTEST_MIN(SELFTEST_MIN),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_force(bus_force), .core_reset(core_reset),
    .selftest_req(selftest_req), .run_len(run_len), .pin_ads_n(pin_ads_n),
    .pin_be_n(pin_be_n), .pin_addr(pin_addr), .pin_wr(pin_wr), .pin_dc(pin_dc),
    .pin_mio(pin_mio), .pin_lock_n(pin_lock_n), .pin_data_out(pin_data_out),
    .pin_data_oe(pin_data_oe), .pin_hlda(pin_hlda), .core_hold(core_hold),
    .core_addr(core_addr), .core_hlda(core_hlda)
);

// File: tb/reset_bus_gate_test.sv
module reset_bus_gate_test;
    localparam int RESET_MIN    = 15;
    localparam int SELFTEST_MIN = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_reset_in = 1'b0;
    logic        hold_req = 1'b0;
    logic        core_hlda = 1'b0;
    logic        core_ads_n = 1'b1;
    logic [3:0]  core_be_n = '0;
    logic [29:0] core_addr = '0;
    logic        core_wr = 1'b0, core_dc = 1'b0, core_mio = 1'b0, core_lock_n = 1'b1;
    logic [31:0] core_data_out = '0;
    logic        core_data_oe = 1'b0;
    logic        pin_ads_n, pin_wr, pin_dc, pin_mio, pin_lock_n, pin_data_oe;
    logic [3:0]  pin_be_n;
    logic [29:0] pin_addr;
    logic [31:0] pin_data_out;
    logic        pin_hlda, core_hold, core_reset, selftest_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    reset_bus_gate uut (
        .clk(clk), .rst_n(rst_n), .cpu_reset_in(cpu_reset_in), .hold_req(hold_req),
        .core_hlda(core_hlda), .core_ads_n(core_ads_n), .core_be_n(core_be_n),
        .core_addr(core_addr), .core_wr(core_wr), .core_dc(core_dc), .core_mio(core_mio),
        .core_lock_n(core_lock_n), .core_data_out(core_data_out), .core_data_oe(core_data_oe),
        .pin_ads_n(pin_ads_n), .pin_be_n(pin_be_n), .pin_addr(pin_addr), .pin_wr(pin_wr),
        .pin_dc(pin_dc), .pin_mio(pin_mio), .pin_lock_n(pin_lock_n),
        .pin_data_out(pin_data_out), .pin_data_oe(pin_data_oe), .pin_hlda(pin_hlda),
        .core_hold(core_hold), .core_reset(core_reset), .selftest_req(selftest_req)
    );

    function automatic logic [71:0] pins_now();
        return {pin_ads_n, pin_data_oe, pin_be_n, pin_addr, pin_wr, pin_dc, pin_mio,
                pin_lock_n, pin_data_out};
    endfunction

    function automatic logic [71:0] core_vec();
        return {core_ads_n, core_data_oe, core_be_n, core_addr, core_wr, core_dc, core_mio,
                core_lock_n, core_data_out};
    endfunction

    function automatic logic [71:0] idle_vec();
        return {1'b1, 1'b0, 4'b0000, {30{1'b1}}, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0};
    endfunction

    function automatic bit exp_qual(int len);
        return len >= RESET_MIN;
    endfunction

    function automatic bit exp_st(int len);
        return len >= SELFTEST_MIN;
    endfunction

    task automatic check(bit ok, string req, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic shuffle_core();
        core_ads_n    = 1'($urandom);
        core_be_n     = 4'($urandom);
        core_addr     = 30'($urandom);
        core_wr       = 1'($urandom);
        core_dc       = 1'($urandom);
        core_mio      = 1'($urandom);
        core_lock_n   = 1'($urandom);
        core_data_out = $urandom;
        core_data_oe  = 1'($urandom);
        hold_req      = 1'($urandom);
        core_hlda     = 1'($urandom);
    endtask

    // Pass-through check at a negedge outside forcing (R8).
    task automatic check_pass(string req);
        check(pins_now() == core_vec(), req, pins_now(), core_vec());
        check(pin_hlda == core_hlda && core_hold == hold_req, req,
              72'({pin_hlda, core_hold}), 72'({core_hlda, hold_req}));
    endtask

    // One reset request of len cycles, with hold granted beforehand.
    task automatic pulse(int len);
        @(negedge clk);
        shuffle_core();
        hold_req  = 1'b1;
        core_hlda = 1'b1;
        #1;
        check(pin_hlda && core_hold, "R8 hold granted before reset", 72'({pin_hlda, core_hold}), 72'(2'b11));
        cpu_reset_in = 1'b1;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (k == 1) begin
                check(pins_now() == idle_vec(), "R3 idle on entry", pins_now(), idle_vec());
                check(!pin_hlda && !core_hold, "R4 reset over prior hold", 72'({pin_hlda, core_hold}), 72'(0));
            end
            if (k == len) begin
                check(pins_now() == idle_vec(), "R3 idle at end", pins_now(), idle_vec());
                check(!pin_hlda && !core_hold, "R4 hold blocked", 72'({pin_hlda, core_hold}), 72'(0));
            end
            shuffle_core();
        end
        cpu_reset_in = 1'b0;
        @(negedge clk);
        check(core_reset == exp_qual(len), exp_qual(len) ? "R2 qualified" : "R1 short rejected",
              72'(core_reset), 72'(exp_qual(len)));
        check(pins_now() == (exp_qual(len) ? idle_vec() : core_vec()), "R3 R8 bus after release",
              pins_now(), exp_qual(len) ? idle_vec() : core_vec());
        check(selftest_req == 1'b0, "R5 no early self test", 72'(selftest_req), 72'(0));
        @(negedge clk);
        check(core_reset == 1'b0, "R2 core reset ends", 72'(core_reset), 72'(0));
        check(selftest_req == exp_st(len),
              len >= 128 ? "R7 saturated width" : (exp_st(len) ? "R5 self test" : "R6 R1 no self test"),
              72'(selftest_req), 72'(exp_st(len)));
        check_pass("R8 pass after reset");
        @(negedge clk);
        check(selftest_req == 1'b0, "R5 single cycle", 72'(selftest_req), 72'(0));
        shuffle_core();
        #1;
        check_pass("R8 pass random");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        cpu_reset_in = 1'b1;
        repeat (4) @(negedge clk);
        check(core_reset == 1'b0 && selftest_req == 1'b0, "R9 block reset",
              72'({core_reset, selftest_req}), 72'(0));
        cpu_reset_in = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        shuffle_core();
        #1;
        check_pass("R8 pass after init");

        pulse(1);
        pulse(14);
        pulse(15);
        pulse(16);
        pulse(79);
        pulse(80);
        pulse(127);
        pulse(130);
        pulse(200);
        for (int i = 0; i < 30; i++) begin
            pulse(1 + int'($urandom_range(0, 159)));
        end

        // Block reset in the middle of a qualified request (R9).
        @(negedge clk);
        cpu_reset_in = 1'b1;
        repeat (30) @(negedge clk);
        check(core_reset == 1'b1, "R2 held during long request", 72'(core_reset), 72'(1));
        rst_n = 1'b0;
        @(negedge clk);
        check(core_reset == 1'b0 && selftest_req == 1'b0, "R9 mid-request clear",
              72'({core_reset, selftest_req}), 72'(0));
        rst_n = 1'b1;
        cpu_reset_in = 1'b0;
        repeat (3) @(negedge clk);
        check(selftest_req == 1'b0 && core_reset == 1'b0, "R9 width restarted",
              72'({core_reset, selftest_req}), 72'(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule